// File: doc/BRIEF.md
# Indexed Address/Data Byte Memory Port

This block lets a host reach a byte-wide memory with a 16-bit address space through a narrow window of four byte offsets. The host first loads an internal address pointer one byte at a time: offset 0 sets the low byte and offset 1 sets the high byte. It then moves a byte through offset 3. A data write stores the byte and returns the pointer to zero, so every write transfer starts by setting the address again. Offset 2 does nothing.

Two fixed 16-byte windows of the memory can each be guarded by a lock bit of their own. A separate toggle request with an index flips one lock bit. While a window is locked, writes to it are dropped and reads from it return 0xFF. The memory is an internal register array whose size is a parameter. Pointer values at or past that size behave like a locked address. Read data is registered and appears one cycle after the read strobe.

Top module: `idx_nvram_port`

## Requirements
- R1: A write to window offset 0 replaces bits [7:0] of the address pointer and leaves bits [15:8] unchanged.
- R2: A write to window offset 1 replaces bits [15:8] of the address pointer and leaves bits [7:0] unchanged.
- R3: A write to window offset 3 stores the data byte at the pointed address when that address is writable. The pointer then becomes 0x0000, whether or not the byte was stored.
- R4: A read strobe at window offset 3 loads the byte at the pointed address into `rd_data`. The value is visible one cycle after the strobe. A read does not move the pointer.
- R5: A read strobe at window offset 0, 1 or 2 gives `rd_data` = 0xFF one cycle later.
- R6: A write to window offset 2 changes neither the pointer nor the memory.
- R7: While lock bit 0 is set, addresses 0x20..0x2F are protected. While lock bit 1 is set, addresses 0x30..0x3F are protected. A write to a protected address is dropped, and a read from it returns 0xFF.
- R8: A toggle request with index `i` inverts lock bit `i` only. The other lock bit keeps its value.
- R9: A pointer at or above `MEM_BYTES` is never written, and a read at such a pointer returns 0xFF. Memory at the low-order alias of that pointer is not disturbed.
- R10: Synchronous reset sets the pointer to 0x0000, clears both lock bits and sets `rd_data` to 0xFF. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the window offset |
| bus_rd | input | 1 | Read strobe for the window offset |
| bus_off | input | 2 | Window offset: 0 low address byte, 1 high address byte, 2 unused, 3 data |
| bus_wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| lock_flip | input | 1 | Request to invert one lock bit |
| lock_sel | input | 1 | Index of the lock bit to invert |

## Verification
The hardest situation to reach from the ports is a protected or out-of-range write whose effect must be shown to be absent. The pointer and the lock bits cannot be seen directly, and a data write clears the pointer. The bench therefore drives each lock configuration through toggle requests, tracked in its own model. It then writes every address on both sides of the guarded windows, re-points, and reads back. A locked address must read 0xFF, and after unlocking it must still hold its old value. Out-of-range pointers are chosen so that their low address bits alias a known in-range byte, which is then read back unchanged.

// File: rtl/idx_nvram_pkg.sv
package idx_nvram_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] FILL_BYTE = '1;

    typedef enum logic [1:0] {
        WIN_ADDR_LO = 2'd0,
        WIN_ADDR_HI = 2'd1,
        WIN_SPARE   = 2'd2,
        WIN_DATA    = 2'd3
    } win_off_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        win_off_e          off;
        logic [BYTE_W-1:0] data;
    } win_req_t;

    function automatic logic in_span(input logic [PTR_W-1:0] a,
                                     input int lo, input int span);
        logic [31:0] aw;
        aw = 32'(a);
        return (aw >= 32'(lo)) && (aw < 32'(lo + span));
    endfunction

endpackage

// File: rtl/nvp_addr_ptr.sv
module nvp_addr_ptr
    import idx_nvram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              clr,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [PTR_W-1:0]  ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (ld_lo) begin
            ptr[BYTE_W-1:0] <= byte_in;
        end else if (ld_hi) begin
            ptr[PTR_W-1:BYTE_W] <= byte_in;
        end
    end

    p_lo_keeps_hi_r1: assert property (@(posedge clk) disable iff (rst)
        (ld_lo && !clr) |=> (ptr[PTR_W-1:BYTE_W] == $past(ptr[PTR_W-1:BYTE_W])));

    p_hi_keeps_lo_r2: assert property (@(posedge clk) disable iff (rst)
        (ld_hi && !ld_lo && !clr) |=> (ptr[BYTE_W-1:0] == $past(ptr[BYTE_W-1:0])));

    p_data_clears_r3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == '0));

    p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
        !(ld_lo || ld_hi || clr) |=> $stable(ptr));

    p_reset_ptr_r10: assert property (@(posedge clk)
        rst |=> (ptr == '0));

endmodule

// File: rtl/nvp_lock_guard.sv
module nvp_lock_guard
    import idx_nvram_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int LOCK_COUNT = 2,
    parameter int LOCK_BASE  = 32,
    parameter int LOCK_SPAN  = 16,
    localparam int SEL_W     = (LOCK_COUNT > 1) ? $clog2(LOCK_COUNT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flip,
    input  logic [SEL_W-1:0] sel,
    input  logic [PTR_W-1:0] ptr,
    output logic             blocked
);

    logic [LOCK_COUNT-1:0] locks;
    logic [LOCK_COUNT-1:0] hit;
    logic                  beyond;

    always_ff @(posedge clk) begin
        if (rst) begin
            locks <= '0;
        end else if (flip && (int'(sel) < LOCK_COUNT)) begin
            locks[sel] <= ~locks[sel];
        end
    end

    for (genvar i = 0; i < LOCK_COUNT; i++) begin : g_region
        localparam int LO = LOCK_BASE + i * LOCK_SPAN;
        assign hit[i] = in_span(ptr, LO, LOCK_SPAN);
    end

    assign beyond  = (32'(ptr) >= 32'(MEM_BYTES));
    assign blocked = beyond || |(hit & locks);

    p_flip_one_bit_r8: assert property (@(posedge clk) disable iff (rst)
        flip |=> ($countones(locks ^ $past(locks)) == 1));

    p_locks_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !flip |=> $stable(locks));

    p_reset_locks_r10: assert property (@(posedge clk)
        rst |=> (locks == '0));

endmodule

// File: rtl/nvp_byte_store.sv
module nvp_byte_store
    import idx_nvram_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    localparam int IDX_W    = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic              re_hit,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= FILL_BYTE;
        end else if (re) begin
            rdata <= re_hit ? mem[idx] : FILL_BYTE;
        end
    end

    p_idle_rdata_r4: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata));

endmodule

// File: rtl/idx_nvram_port.sv
module idx_nvram_port
    import idx_nvram_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int LOCK_COUNT = 2,
    parameter int LOCK_BASE  = 32,
    parameter int LOCK_SPAN  = 16,
    localparam int IDX_W     = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
    localparam int SEL_W     = (LOCK_COUNT > 1) ? $clog2(LOCK_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_off,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              lock_flip,
    input  logic [SEL_W-1:0]  lock_sel
);

    win_req_t         req;
    logic [PTR_W-1:0] ptr;
    logic             blocked;
    logic             data_wr;
    logic             data_rd;

    assign req.wr   = bus_wr;
    assign req.rd   = bus_rd;
    assign req.off  = win_off_e'(bus_off);
    assign req.data = bus_wdata;

    assign data_wr = req.wr && (req.off == WIN_DATA);
    assign data_rd = req.rd && (req.off == WIN_DATA);

    nvp_addr_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ld_lo   (req.wr && (req.off == WIN_ADDR_LO)),
        .ld_hi   (req.wr && (req.off == WIN_ADDR_HI)),
        .clr     (data_wr),
        .byte_in (req.data),
        .ptr     (ptr)
    );

    nvp_lock_guard #(
        .MEM_BYTES  (MEM_BYTES),
        .LOCK_COUNT (LOCK_COUNT),
        .LOCK_BASE  (LOCK_BASE),
        .LOCK_SPAN  (LOCK_SPAN)
    ) u_guard (
        .clk     (clk),
        .rst     (rst),
        .flip    (lock_flip),
        .sel     (lock_sel),
        .ptr     (ptr),
        .blocked (blocked)
    );

    nvp_byte_store #(
        .MEM_BYTES (MEM_BYTES)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (data_wr && !blocked),
        .re     (req.rd),
        .re_hit (data_rd && !blocked),
        .idx    (ptr[IDX_W-1:0]),
        .wdata  (req.data),
        .rdata  (rd_data)
    );

    p_side_read_ff_r5: assert property (@(posedge clk) disable iff (rst)
        (req.rd && (req.off != WIN_DATA)) |=> (rd_data == FILL_BYTE));

    p_guarded_read_ff_r7: assert property (@(posedge clk) disable iff (rst)
        (data_rd && blocked) |=> (rd_data == FILL_BYTE));

    p_oob_read_ff_r9: assert property (@(posedge clk) disable iff (rst)
        (data_rd && (32'(ptr) >= 32'(MEM_BYTES))) |=> (rd_data == FILL_BYTE));

endmodule

// File: tb/idx_nvram_port_test.sv
module idx_nvram_port_test;

    localparam int MB = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_off = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] rd_data;
    logic       lock_flip = 1'b0;
    logic       lock_sel = 1'b0;

    int tests = 0;
    int fails = 0;
    logic [7:0] model [MB];
    logic [1:0] lk = 2'b00;

    always #5 clk = ~clk;

    idx_nvram_port #(.MEM_BYTES(MB)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .lock_flip(lock_flip), .lock_sel(lock_sel)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] off, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_off = off; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] off, output logic [7:0] q);
        @(negedge clk); bus_rd = 1'b1; bus_off = off;
        @(negedge clk); bus_rd = 1'b0; q = rd_data;
    endtask

    task automatic set_ptr(input logic [15:0] a);
        wr(2'd0, a[7:0]);
        wr(2'd1, a[15:8]);
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        set_ptr(a);
        wr(2'd3, d);
    endtask

    task automatic peek(input logic [15:0] a, output logic [7:0] q);
        set_ptr(a);
        rd(2'd3, q);
    endtask

    task automatic flip(input logic i);
        @(negedge clk); lock_flip = 1'b1; lock_sel = i;
        @(negedge clk); lock_flip = 1'b0;
        lk[i] = ~lk[i];
    endtask

    function automatic logic locked_at(input int a);
        return (lk[0] && a >= 32 && a < 48) || (lk[1] && a >= 48 && a < 64);
    endfunction

    initial begin
        logic [7:0] q;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 rd_data after reset", rd_data, 8'hFF);

        // R3/R4: fill everything, read everything back
        for (int a = 0; a < MB; a++) begin
            model[a] = 8'(a * 29 + 7);
            poke(16'(a), model[a]);
        end
        for (int a = 0; a < MB; a++) begin
            peek(16'(a), q);
            check("R4 readback", q, model[a]);
        end

        // R4: read does not move pointer
        peek(16'h0041, q);
        rd(2'd3, q);
        check("R4 repeat read same address", q, model[8'h41]);

        // R3: pointer is zero after a data write
        poke(16'h0045, 8'hC3); model[8'h45] = 8'hC3;
        rd(2'd3, q);
        check("R3 pointer cleared", q, model[0]);
        peek(16'h0045, q);
        check("R3 stored byte", q, 8'hC3);

        // R1/R2: independent byte loads
        wr(2'd1, 8'h01); wr(2'd0, 8'h10);
        rd(2'd3, q);
        check("R9 pointer 0x0110 reads FF", q, 8'hFF);
        wr(2'd0, 8'h20);
        rd(2'd3, q);
        check("R1 low load keeps high byte", q, 8'hFF);
        wr(2'd1, 8'h00);
        rd(2'd3, q);
        check("R2 high load keeps low byte", q, model[8'h20]);
        wr(2'd0, 8'h05);
        rd(2'd3, q);
        check("R1 low load replaces low byte", q, model[8'h05]);

        // R5: side offsets read FF
        for (int o = 0; o < 3; o++) begin
            rd(2'(o), q);
            check("R5 side offset read", q, 8'hFF);
        end

        // R6: offset 2 write changes nothing
        set_ptr(16'h0007);
        wr(2'd2, 8'hAA);
        rd(2'd3, q);
        check("R6 pointer unchanged by offset 2", q, model[7]);
        peek(16'h0000, q);
        check("R6 memory unchanged by offset 2", q, model[0]);

        // R7/R8: every lock configuration over the guarded windows
        for (int cfg = 0; cfg < 4; cfg++) begin
            if (lk[0] != cfg[0]) flip(1'b0);
            if (lk[1] != cfg[1]) flip(1'b1);
            for (int a = 30; a < 66; a++) begin
                logic [7:0] v;
                v = 8'(a * 13 + cfg * 71 + 1);
                poke(16'(a), v);
                if (!locked_at(a)) model[a] = v;
                peek(16'(a), q);
                check("R7 guarded window access", q, locked_at(a) ? 8'hFF : model[a]);
            end
        end
        if (lk[0]) flip(1'b0);
        if (lk[1]) flip(1'b1);
        for (int a = 30; a < 66; a++) begin
            peek(16'(a), q);
            check("R7 dropped writes left old data", q, model[a]);
        end

        // R8: flipping one bit twice restores, other bit untouched
        flip(1'b1);
        peek(16'h0025, q);
        check("R8 lock1 leaves window 0 open", q, model[8'h25]);
        peek(16'h0035, q);
        check("R8 lock1 guards window 1", q, 8'hFF);
        flip(1'b1);
        peek(16'h0035, q);
        check("R8 second flip reopens", q, model[8'h35]);

        // R9: out of range writes do not alias
        poke(16'h0090, 8'h5A);
        peek(16'h0090, q);
        check("R9 out of range read", q, 8'hFF);
        peek(16'h0010, q);
        check("R9 alias untouched", q, model[8'h10]);
        poke(16'hFFC0, 8'h66);
        peek(16'h0040, q);
        check("R9 high pointer alias untouched", q, model[8'h40]);

        // R10: mid-run reset clears pointer and locks, keeps memory
        flip(1'b0); flip(1'b1);
        set_ptr(16'h0033);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; lk = 2'b00;
        check("R10 rd_data after mid reset", rd_data, 8'hFF);
        rd(2'd3, q);
        check("R10 pointer cleared", q, model[0]);
        peek(16'h0025, q);
        check("R10 lock 0 cleared", q, model[8'h25]);
        poke(16'h0036, 8'h99);
        peek(16'h0036, q);
        check("R10 lock 1 cleared", q, 8'h99);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule